// File: doc/BRIEF.md
# SHA-512 Half-Word Sigma Unit

This combinational function unit serves a 32-bit processor core that must run the SHA-512 compression and message-expansion functions without 64-bit registers. One 64-bit operand is held in two 32-bit source registers: the first source holds the lower word and the second holds the upper word. One of six operations is chosen by a 3-bit code. The unit forms the 64-bit working value, applies that operation's mix of rotations and shifts, and returns only the lower 32 bits of the result.

Software gets the full 64-bit big-sigma value by issuing the same operation twice with the sources swapped. For the small-sigma functions it issues a low-half and a high-half operation. The unit also checks whether the operation may run. It is legal only on a 32-bit core with the SHA-2 hash feature enabled and with a defined operation code. Otherwise it raises an illegal flag and drives a zero result.

The design has no states. The style's state names and transitions therefore reduce to a code decoder, a term generator and a gated output selector.

Top module: `sha512_half_sigma`

## Requirements
- R1: The working value W is {i_hi, i_lo}, with i_hi in bits 63:32 and i_lo in bits 31:0. Each result is bits 31:0 of the XOR of three 64-bit terms.
- R2: Code 3'd0 (big-sigma-0 half) XORs W rotated left by 25, W rotated left by 30 and W rotated right by 28.
- R3: Code 3'd1 (big-sigma-1 half) XORs W rotated right by 14, W rotated right by 18 and W rotated left by 23.
- R4: Code 3'd2 (small-sigma-0 low) XORs W rotated right by 1, by 7 and by 8.
- R5: Code 3'd3 (small-sigma-0 high) XORs W rotated right by 1, W rotated right by 8, and i_lo zero-extended to 64 bits then shifted right logically by 7.
- R6: Code 3'd4 (small-sigma-1 low) XORs W rotated right by 6, W rotated right by 19 and W rotated left by 3.
- R7: Code 3'd5 (small-sigma-1 high) XORs W rotated left by 3, W rotated right by 19, and i_lo zero-extended then shifted right logically by 6.
- R8: When i_xlen64 is 1 or i_sha_en is 0, o_illegal is 1 and o_res is 0, whatever the code.
- R9: Codes 3'd6 and 3'd7 set o_illegal to 1 and o_res to 0.
- R10: With i_xlen64 = 0, i_sha_en = 1 and a code from 0 to 5, o_illegal is 0.
- R11: Paired operations rebuild the 64-bit SHA-512 functions of x. Code 0 on (x_lo, x_hi) gives bits 31:0 of big-sigma-0 of x, and code 0 on (x_hi, x_lo) gives bits 63:32. Code 1 does the same for big-sigma-1. Codes 2 and 3 give small-sigma-0 low and high, and codes 4 and 5 give small-sigma-1 low and high. In every high-half use, i_lo carries x_hi and i_hi carries x_lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_lo | input | 32 | First source register, lower word of W |
| i_hi | input | 32 | Second source register, upper word of W |
| i_op | input | 3 | Operation code, 0 to 5 defined |
| i_xlen64 | input | 1 | 1 when the core runs with 64-bit registers |
| i_sha_en | input | 1 | SHA-2 hash feature enable |
| o_res | output | 32 | Lower 32 bits of the selected function |
| o_illegal | output | 1 | Operation not permitted; result forced to zero |

## Verification
The assertions are immediate checks on a purely combinational block. They are evaluated only when every input is a known 0 or 1, so they assume the core presents fully driven operands and controls. The stimulus changes inputs only between sampling points and never drives X or Z. It walks all eight codes under each legality combination, including the undefined codes. Only the linear property (zero operands give a zero result) is asserted for the data path. The exact values are left to the bench, which models the full 64-bit SHA-512 functions.

// File: rtl/sha_half_pkg.sv
package sha_half_pkg;

    localparam int WORD_W  = 32;
    localparam int DWORD_W = 2 * WORD_W;
    localparam int NUM_OPS = 6;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_BIG0     = 3'd0,
        OP_BIG1     = 3'd1,
        OP_SMALL0_L = 3'd2,
        OP_SMALL0_H = 3'd3,
        OP_SMALL1_L = 3'd4,
        OP_SMALL1_H = 3'd5,
        OP_RSVD6    = 3'd6,
        OP_RSVD7    = 3'd7
    } op_e;

    // Right rotation of a double word; amount always in 1..DWORD_W-1.
    function automatic logic [DWORD_W-1:0] ror_dw(input logic [DWORD_W-1:0] v,
                                                  input int amt);
        return (v >> amt) | (v << (DWORD_W - amt));
    endfunction

endpackage

// File: rtl/sha_half_decode.sv
module sha_half_decode
    import sha_half_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            xlen64,
    input  logic            sha_en,
    output logic            legal
);
    op_e code;
    logic known;

    always_comb begin
        code  = op_e'(op);
        known = 1'b0;
        unique case (code)
            OP_BIG0, OP_BIG1, OP_SMALL0_L, OP_SMALL0_H,
            OP_SMALL1_L, OP_SMALL1_H: known = 1'b1;
            OP_RSVD6, OP_RSVD7:       known = 1'b0;
            default:                  known = 1'b0;
        endcase
        legal = known && !xlen64 && sha_en;
    end
endmodule

// File: rtl/sha_half_terms.sv
module sha_half_terms
    import sha_half_pkg::*;
(
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    output logic [WORD_W-1:0] res [NUM_OPS]
);
    // Every left rotation by n is written as a right rotation by 64-n.
    localparam int ROT_A [NUM_OPS] = '{39, 14, 1, 1, 6, 61};
    localparam int ROT_B [NUM_OPS] = '{34, 18, 7, 7, 19, 6};
    localparam int ROT_C [NUM_OPS] = '{28, 41, 8, 8, 61, 19};
    // Ops whose middle term is a logical shift of the zero-extended lower word.
    localparam bit MID_SHIFT [NUM_OPS] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

    logic [DWORD_W-1:0] w;
    assign w = {hi, lo};

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        logic [DWORD_W-1:0] t_a, t_b, t_c, mix;
        assign t_a = ror_dw(w, ROT_A[g]);
        assign t_c = ror_dw(w, ROT_C[g]);
        if (MID_SHIFT[g]) begin : g_shift
            assign t_b = {{WORD_W{1'b0}}, lo} >> ROT_B[g];
        end else begin : g_rot
            assign t_b = ror_dw(w, ROT_B[g]);
        end
        assign mix    = t_a ^ t_b ^ t_c;
        assign res[g] = mix[WORD_W-1:0];
    end
endmodule

// File: rtl/sha_half_select.sv
module sha_half_select
    import sha_half_pkg::*;
(
    input  logic [WORD_W-1:0] cand [NUM_OPS],
    input  logic [OP_W-1:0]   op,
    input  logic              legal,
    output logic [WORD_W-1:0] res,
    output logic              illegal
);
    always_comb begin
        res = '0;
        for (int k = 0; k < NUM_OPS; k++) begin
            if (legal && (op == OP_W'(k))) res = cand[k];
        end
        illegal = !legal;
    end
endmodule

// File: rtl/sha512_half_sigma.sv
module sha512_half_sigma
    import sha_half_pkg::*;
(
    input  logic [31:0] i_lo,
    input  logic [31:0] i_hi,
    input  logic [2:0]  i_op,
    input  logic        i_xlen64,
    input  logic        i_sha_en,
    output logic [31:0] o_res,
    output logic        o_illegal
);
    logic              legal;
    logic [WORD_W-1:0] cand [NUM_OPS];

    sha_half_decode u_dec (
        .op     (i_op),
        .xlen64 (i_xlen64),
        .sha_en (i_sha_en),
        .legal  (legal)
    );

    sha_half_terms u_terms (
        .lo  (i_lo),
        .hi  (i_hi),
        .res (cand)
    );

    sha_half_select u_sel (
        .cand    (cand),
        .op      (i_op),
        .legal   (legal),
        .res     (o_res),
        .illegal (o_illegal)
    );
endmodule

// File: rtl/sha512_half_sigma_chk.sv
module sha512_half_sigma_chk (
    input logic [31:0] i_lo,
    input logic [31:0] i_hi,
    input logic [2:0]  i_op,
    input logic        i_xlen64,
    input logic        i_sha_en,
    input logic [31:0] o_res,
    input logic        o_illegal
);
    logic known;
    assign known = !$isunknown({i_lo, i_hi, i_op, i_xlen64, i_sha_en, o_res, o_illegal});

    always_comb begin
        if (known) begin
            a_r8_illegal_zero_result: assert (!o_illegal || o_res == 32'd0);
            a_r8_gate_blocks: assert (!(i_xlen64 || !i_sha_en) || o_illegal);
            a_r9_reserved_code: assert (!(i_op[2] && i_op[1]) || o_illegal);
            a_r10_legal_clear: assert (!(!i_xlen64 && i_sha_en && i_op <= 3'd5) || !o_illegal);
            a_r1_zero_in_zero_out: assert (!(i_lo == 32'd0 && i_hi == 32'd0) || o_res == 32'd0);
        end
    end
endmodule

bind sha512_half_sigma sha512_half_sigma_chk u_chk (.*);

// File: tb/test_sha512_half_sigma.sv
module test_sha512_half_sigma;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] i_lo = '0, i_hi = '0;
    logic [2:0]  i_op = '0;
    logic        i_xlen64 = 1'b0, i_sha_en = 1'b0;
    logic [31:0] o_res;
    logic        o_illegal;
    int n_chk = 0, n_fail = 0;
    logic [63:0] lcg = 64'h0123_4567_89ab_cdef;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha512_half_sigma i_sha512_half_sigma (.*);

    function automatic logic [63:0] rr(input logic [63:0] x, input int n);
        return (x >> n) | (x << (64 - n));
    endfunction
    function automatic logic [63:0] f_big0(input logic [63:0] x);
        return rr(x, 28) ^ rr(x, 34) ^ rr(x, 39);
    endfunction
    function automatic logic [63:0] f_big1(input logic [63:0] x);
        return rr(x, 14) ^ rr(x, 18) ^ rr(x, 41);
    endfunction
    function automatic logic [63:0] f_sm0(input logic [63:0] x);
        return rr(x, 1) ^ rr(x, 8) ^ (x >> 7);
    endfunction
    function automatic logic [63:0] f_sm1(input logic [63:0] x);
        return rr(x, 19) ^ rr(x, 61) ^ (x >> 6);
    endfunction

    // Expected half for one op applied to (lo, hi), from 64-bit definitions.
    function automatic logic [31:0] f_expect(input logic [2:0] op,
                                             input logic [31:0] lo, input logic [31:0] hi);
        logic [63:0] w, s;
        w = {hi, lo};
        s = {lo, hi};
        case (op)
            3'd0: return f_big0(w)[31:0];
            3'd1: return f_big1(w)[31:0];
            3'd2: return f_sm0(w)[31:0];
            3'd3: return f_sm0(s)[63:32];
            3'd4: return f_sm1(w)[31:0];
            3'd5: return f_sm1(s)[63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [31:0] lo, input logic [31:0] hi, input logic [2:0] op,
                         input logic x64, input logic en);
        @(negedge clk);
        i_lo = lo; i_hi = hi; i_op = op; i_xlen64 = x64; i_sha_en = en;
        #1;
    endtask

    function automatic logic [63:0] next_rand();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg;
    endfunction

    task automatic t_reset_state();
        drive('0, '0, 3'd0, 1'b0, 1'b0);
        check("R8 reset illegal", {31'd0, o_illegal}, 32'd1);
        check("R8 reset result", o_res, 32'd0);
    endtask

    task automatic t_each_op(input logic [2:0] op, input string req);
        logic [31:0] pats [4] = '{32'h0000_0001, 32'h8000_0000, 32'hdead_beef, 32'h1234_5678};
        for (int p = 0; p < 4; p++) begin
            drive(pats[p], pats[3-p] ^ 32'h5a5a_0f0f, op, 1'b0, 1'b1);
            check(req, o_res, f_expect(op, pats[p], pats[3-p] ^ 32'h5a5a_0f0f));
            check("R10 legal flag", {31'd0, o_illegal}, 32'd0);
        end
    endtask

    task automatic t_gating();
        for (int op = 0; op < 8; op++) begin
            drive(32'hffff_ffff, 32'h1357_9bdf, 3'(op), 1'b1, 1'b1);
            check("R8 xlen64 flag", {31'd0, o_illegal}, 32'd1);
            check("R8 xlen64 result", o_res, 32'd0);
            drive(32'hffff_ffff, 32'h1357_9bdf, 3'(op), 1'b0, 1'b0);
            check("R8 disabled flag", {31'd0, o_illegal}, 32'd1);
            check("R8 disabled result", o_res, 32'd0);
        end
    endtask

    task automatic t_reserved();
        for (int op = 6; op < 8; op++) begin
            drive(32'hcafe_f00d, 32'h0bad_cafe, 3'(op), 1'b0, 1'b1);
            check("R9 reserved flag", {31'd0, o_illegal}, 32'd1);
            check("R9 reserved result", o_res, 32'd0);
        end
    endtask

    task automatic t_pairing(input int rounds);
        for (int r = 0; r < rounds; r++) begin
            logic [63:0] x;
            x = next_rand();
            drive(x[31:0], x[63:32], 3'd0, 1'b0, 1'b1);  check("R11 big0 lo", o_res, f_big0(x)[31:0]);
            drive(x[63:32], x[31:0], 3'd0, 1'b0, 1'b1);  check("R11 big0 hi", o_res, f_big0(x)[63:32]);
            drive(x[31:0], x[63:32], 3'd1, 1'b0, 1'b1);  check("R11 big1 lo", o_res, f_big1(x)[31:0]);
            drive(x[63:32], x[31:0], 3'd1, 1'b0, 1'b1);  check("R11 big1 hi", o_res, f_big1(x)[63:32]);
            drive(x[31:0], x[63:32], 3'd2, 1'b0, 1'b1);  check("R11 sm0 lo", o_res, f_sm0(x)[31:0]);
            drive(x[63:32], x[31:0], 3'd3, 1'b0, 1'b1);  check("R11 sm0 hi", o_res, f_sm0(x)[63:32]);
            drive(x[31:0], x[63:32], 3'd4, 1'b0, 1'b1);  check("R11 sm1 lo", o_res, f_sm1(x)[31:0]);
            drive(x[63:32], x[31:0], 3'd5, 1'b0, 1'b1);  check("R11 sm1 hi", o_res, f_sm1(x)[63:32]);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_each_op(3'd0, "R2 R1 big0");
        t_each_op(3'd1, "R3 big1");
        t_each_op(3'd2, "R4 sm0 low");
        t_each_op(3'd3, "R5 sm0 high");
        t_each_op(3'd4, "R6 sm1 low");
        t_each_op(3'd5, "R7 sm1 high");
        t_gating();
        t_reserved();
        t_pairing(50);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule